// File: doc/BRIEF.md
# ADC Offset Calibration Unit

This block sits behind the decimation filter of a delta-sigma converter. It removes the converter's zero-input error from every result. A calibration cycle starts on a request. The block then takes both input multiplexers off line and closes a switch that ties the converter input to common mode. It waits for the first filter output that is marked settled and keeps that word as a 16-bit two's-complement offset. Outside calibration, each raw conversion has the stored offset subtracted from it, and the corrected value goes to the data register with a one-cycle strobe.

In unipolar mode the raw word is unsigned and the offset counts twice. In bipolar mode the raw word is signed and the offset counts once. The subtraction saturates at the limits of the active range. A host can load the offset register directly. A configuration change sets a flag that says the offset no longer matches the converter setup. The change can be to gain, input range, input buffering or output rate.

Top module: `adc_offset_cal`

## Requirements
- R1: While `rst` is high at a clock edge, every output is forced to 0 after that edge: `data_ready`, `mux_disable`, `input_short`, `data_strobe`, `recal_needed`, `data_out` and `offset_value`.
- R2: Suppose `cal_req` is high at an edge while no calibration is running. From the next cycle, `data_ready`, `mux_disable` and `input_short` are all 1. They stay 1 until the calibration ends.
- R3: During calibration, a `conv_valid` word with `conv_settled`=0 is discarded, and the offset stays unchanged. The first `conv_valid` word with `conv_settled`=1 is stored in `offset_value` one cycle later. In that same cycle, `data_ready`, `mux_disable` and `input_short` return to 0.
- R4: A `cal_req` pulse that arrives while calibration is running has no effect. The calibration still ends only on a settled word.
- R5: Outside calibration, a `conv_valid` word in bipolar mode (`cfg_unipolar`=0) is read as signed. One cycle later, `data_out` = raw − offset and `data_strobe` pulses for one cycle. With a zero offset, `data_out` equals the raw word.
- R6: In unipolar mode (`cfg_unipolar`=1) the raw word is unsigned. `data_out` = raw − 2×offset, clamped to 0..65535. For example, offset +2 shifts the result by −4.
- R7: In bipolar mode, the result clamps to −32768..32767 instead of wrapping.
- R8: A `conv_valid` word that arrives during calibration gives no `data_strobe` and leaves `data_out` unchanged.
- R9: `host_wr` loads `host_offset` into `offset_value` one cycle later and clears `recal_needed`. Conversions after that edge use the new value.
- R10: Suppose any of `cfg_gain`, `cfg_unipolar`, `cfg_buffered` or `cfg_fast_rate` differs from its value at the previous edge. Then `recal_needed` is 1 after that edge. A completed calibration clears the flag. A change in the same cycle as a clear wins.
- R11: Suppose a calibration capture and `host_wr` occur at the same edge. The captured word is stored and the host value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Start an offset calibration |
| cfg_gain | input | 2 | Amplifier gain setting |
| cfg_unipolar | input | 1 | 1 = unipolar range, 0 = bipolar |
| cfg_buffered | input | 1 | Input buffer enabled |
| cfg_fast_rate | input | 1 | Fast output rate selected |
| conv_valid | input | 1 | Filter output word present |
| conv_settled | input | 1 | Filter output has fully settled |
| conv_raw | input | 16 | Raw filter output word |
| host_wr | input | 1 | Host write of the offset register |
| host_offset | input | 16 | Offset value written by the host |
| mux_disable | output | 1 | Disables both input multiplexers |
| input_short | output | 1 | Ties converter input to common mode |
| data_ready | output | 1 | High for the whole calibration cycle |
| data_out | output | 16 | Corrected data register |
| data_strobe | output | 1 | One-cycle pulse when data_out is written |
| offset_value | output | 16 | Stored two's-complement offset |
| recal_needed | output | 1 | Configuration changed since last offset load |

## Verification
The bench pushes the subtraction against both clamp rails in each mode. A design that wraps would return a large value of the wrong sign at the rails. A design that forgot the double weight would be off by exactly the offset in unipolar mode. Unsettled words, repeated requests during calibration, and a capture that coincides with a host write are all driven. A design that captured too early, restarted, or let the host win would store the wrong offset. Each configuration field is toggled on its own and together with a calibration end. A design that missed a field, or let the clear beat the set, would leave the flag low.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    localparam int DATA_W = 16;
    localparam int GAIN_W = 2;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_CAL = 1'b1
    } cal_state_e;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              unipolar;
        logic              buffered;
        logic              fast_rate;
    } adc_cfg_t;

    function automatic logic cfg_differs(adc_cfg_t a, adc_cfg_t b);
        return (a != b);
    endfunction

endpackage

// File: rtl/ofc_cal_ctrl.sv
module ofc_cal_ctrl
    import ofc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cal_req,
    input  logic in_vld,
    input  logic in_settled,
    output logic cal_active,
    output logic capture
);

    cal_state_e state_q, state_d;

    always_comb begin
        capture = (state_q == ST_CAL) && in_vld && in_settled;
        state_d = state_q;
        case (state_q)
            ST_RUN: if (cal_req) state_d = ST_CAL;
            ST_CAL: if (capture) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign cal_active = (state_q == ST_CAL);

    AST_CAL_START: assert property (@(posedge clk) disable iff (rst)
        (!cal_active && cal_req) |=> cal_active); // R2
    AST_CAL_END: assert property (@(posedge clk) disable iff (rst)
        (cal_active && in_vld && in_settled) |=> !cal_active); // R3
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cal_active && cal_req && !(in_vld && in_settled)) |=> cal_active); // R4

endmodule

// File: rtl/ofc_offset_store.sv
module ofc_offset_store
    import ofc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] cap_data,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    input  adc_cfg_t      cfg,
    output logic [DW-1:0] off_q,
    output logic          recal_q
);

    adc_cfg_t prev_cfg;
    logic     cfg_chg;

    assign cfg_chg = cfg_differs(cfg, prev_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q    <= '0;
            recal_q  <= 1'b0;
            prev_cfg <= cfg;
        end else begin
            prev_cfg <= cfg;
            if (capture)      off_q <= cap_data;
            else if (host_wr) off_q <= host_data;
            if (cfg_chg)                  recal_q <= 1'b1;
            else if (capture || host_wr)  recal_q <= 1'b0;
        end
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        capture |=> (off_q == $past(cap_data))); // R11
    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !capture) |=> (off_q == $past(host_data))); // R9
    AST_CFG_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cfg != prev_cfg) |=> recal_q); // R10

endmodule

// File: rtl/ofc_corrector.sv
module ofc_corrector
    import ofc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic          is_cal,
    input  logic          unipolar,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] off,
    output logic [DW-1:0] dout,
    output logic          dstb
);

    localparam int XW = 3;
    localparam int EW = DW + XW;
    localparam logic signed [EW-1:0] U_HI = {{XW{1'b0}}, {DW{1'b1}}};
    localparam logic signed [EW-1:0] U_LO = '0;
    localparam logic signed [EW-1:0] B_HI = {{(XW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [EW-1:0] B_LO = {{(XW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [EW-1:0] raw_x, off_x, diff, hi, lo;
    logic [DW-1:0]        sat;
    logic                 take;

    always_comb begin
        raw_x = unipolar ? {{XW{1'b0}}, raw} : {{XW{raw[DW-1]}}, raw};
        off_x = {{XW{off[DW-1]}}, off};
        if (unipolar) off_x = off_x <<< 1;
        diff  = raw_x - off_x;
        hi    = unipolar ? U_HI : B_HI;
        lo    = unipolar ? U_LO : B_LO;
        if (diff > hi)      sat = hi[DW-1:0];
        else if (diff < lo) sat = lo[DW-1:0];
        else                sat = diff[DW-1:0];
    end

    assign take = in_vld && !is_cal;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            dstb <= 1'b0;
        end else begin
            dstb <= take;
            if (take) dout <= sat;
        end
    end

    AST_NO_STB_IN_CAL: assert property (@(posedge clk) disable iff (rst)
        (in_vld && is_cal) |=> (!dstb && $stable(dout))); // R8
    AST_ZERO_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
        (take && off == '0) |=> (dstb && dout == $past(raw))); // R5

endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
    import ofc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_req,
    input  logic [GAIN_W-1:0]   cfg_gain,
    input  logic                cfg_unipolar,
    input  logic                cfg_buffered,
    input  logic                cfg_fast_rate,
    input  logic                conv_valid,
    input  logic                conv_settled,
    input  logic [DATA_W-1:0]   conv_raw,
    input  logic                host_wr,
    input  logic [DATA_W-1:0]   host_offset,
    output logic                mux_disable,
    output logic                input_short,
    output logic                data_ready,
    output logic [DATA_W-1:0]   data_out,
    output logic                data_strobe,
    output logic [DATA_W-1:0]   offset_value,
    output logic                recal_needed
);

    adc_cfg_t cfg;
    logic     cal_active, capture;

    assign cfg = '{gain: cfg_gain, unipolar: cfg_unipolar,
                   buffered: cfg_buffered, fast_rate: cfg_fast_rate};

    ofc_cal_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cal_req    (cal_req),
        .in_vld     (conv_valid),
        .in_settled (conv_settled),
        .cal_active (cal_active),
        .capture    (capture)
    );

    ofc_offset_store #(.DW(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .cap_data  (conv_raw),
        .host_wr   (host_wr),
        .host_data (host_offset),
        .cfg       (cfg),
        .off_q     (offset_value),
        .recal_q   (recal_needed)
    );

    ofc_corrector #(.DW(DATA_W)) u_corr (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (conv_valid),
        .is_cal   (cal_active),
        .unipolar (cfg_unipolar),
        .raw      (conv_raw),
        .off      (offset_value),
        .dout     (data_out),
        .dstb     (data_strobe)
    );

    assign mux_disable = cal_active;
    assign input_short = cal_active;
    assign data_ready  = cal_active;

    AST_UNSETTLED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (data_ready && conv_valid && !conv_settled && !host_wr) |=> $stable(offset_value)); // R3
    AST_CAL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (data_ready && conv_valid && conv_settled && $stable(cfg)) |=> !recal_needed); // R10

endmodule

// File: tb/sim_adc_offset_cal.sv
module sim_adc_offset_cal;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, cal_req = 1'b0;
    logic [1:0]  cfg_gain = 2'd0;
    logic        cfg_unipolar = 1'b0, cfg_buffered = 1'b0, cfg_fast_rate = 1'b0;
    logic        conv_valid = 1'b0, conv_settled = 1'b0;
    logic [15:0] conv_raw = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_offset = '0;

    logic        mux_disable, input_short, data_ready, data_strobe, recal_needed;
    logic [15:0] data_out, offset_value;

    adc_offset_cal u0 (
        .clk(clk), .rst(rst), .cal_req(cal_req), .cfg_gain(cfg_gain),
        .cfg_unipolar(cfg_unipolar), .cfg_buffered(cfg_buffered),
        .cfg_fast_rate(cfg_fast_rate), .conv_valid(conv_valid),
        .conv_settled(conv_settled), .conv_raw(conv_raw), .host_wr(host_wr),
        .host_offset(host_offset), .mux_disable(mux_disable),
        .input_short(input_short), .data_ready(data_ready), .data_out(data_out),
        .data_strobe(data_strobe), .offset_value(offset_value),
        .recal_needed(recal_needed)
    );

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // reference state (values expected after the next edge)
    bit          m_cal = 0, m_stb = 0, m_recal = 0;
    logic [15:0] m_off = '0, m_dout = '0;
    logic [4:0]  m_prev = '0;

    function automatic logic [15:0] ref_corr(logic [15:0] raw, logic [15:0] off, bit uni);
        int r, o, v, hi, lo;
        r  = uni ? int'(raw) : int'($signed(raw));
        o  = int'($signed(off));
        v  = r - (uni ? 2 : 1) * o;
        hi = uni ? 65535 : 32767;
        lo = uni ? 0 : -32768;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v[15:0];
    endfunction

    task automatic model_step();
        logic [4:0] cfgv;
        bit cap;
        cfgv = {cfg_gain, cfg_unipolar, cfg_buffered, cfg_fast_rate};
        if (rst) begin
            m_cal = 0; m_stb = 0; m_recal = 0; m_off = '0; m_dout = '0; m_prev = cfgv;
            return;
        end
        cap = m_cal && conv_valid && conv_settled;
        m_stb = conv_valid && !m_cal;
        if (m_stb) m_dout = ref_corr(conv_raw, m_off, cfg_unipolar);
        if (cfgv != m_prev)          m_recal = 1;
        else if (cap || host_wr)     m_recal = 0;
        if (cap)          m_off = conv_raw;
        else if (host_wr) m_off = host_offset;
        m_prev = cfgv;
        m_cal  = m_cal ? !cap : cal_req;
    endtask

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("data_ready",   16'(data_ready),   16'(m_cal));
        chk("mux_disable",  16'(mux_disable),  16'(m_cal));
        chk("input_short",  16'(input_short),  16'(m_cal));
        chk("data_strobe",  16'(data_strobe),  16'(m_stb));
        chk("data_out",     data_out,          m_dout);
        chk("offset_value", offset_value,      m_off);
        chk("recal_needed", 16'(recal_needed), 16'(m_recal));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        cal_req = 0; conv_valid = 0; conv_settled = 0; host_wr = 0;
    endtask

    task automatic conv(logic [15:0] raw, bit settled);
        conv_valid = 1; conv_settled = settled; conv_raw = raw;
        tick();
    endtask

    task automatic hwr(logic [15:0] v);
        host_wr = 1; host_offset = v;
        tick();
    endtask

    task automatic creq();
        cal_req = 1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        conv_valid = 1; conv_raw = 16'h1234;
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        tick();

        tag = "R5";
        conv(16'h0064, 0);
        conv(16'hFF00, 0);
        tag = "R9";
        hwr(16'd5);
        conv(16'd100, 0);
        conv(16'hFFFB, 0);

        tag = "R7";
        hwr(16'h8000);
        conv(16'h7FFF, 0);
        conv(16'h0000, 0);
        hwr(16'h0001);
        conv(16'h8000, 0);
        hwr(16'h7FFF);
        conv(16'h8005, 0);

        tag = "R6";
        cfg_unipolar = 1; tick();
        hwr(16'd2);
        conv(16'd100, 0);
        conv(16'd3, 0);
        hwr(16'hFFFB);
        conv(16'hFFFF, 0);
        conv(16'h8000, 0);

        tag = "R2";
        creq();
        tick();
        tag = "R8";
        conv(16'h0AAA, 0);
        tag = "R4";
        creq();
        tag = "R3";
        conv(16'h0BBB, 0);
        conv(16'h0010, 1);
        tick();
        conv(16'd100, 1);

        tag = "R11";
        cfg_unipolar = 0; tick();
        creq();
        host_wr = 1; host_offset = 16'h5555;
        conv(16'hFFF0, 1);
        conv(16'h0000, 0);

        tag = "R10";
        cfg_gain = 2'd1; tick();
        hwr(16'd0);
        cfg_buffered = 1; tick();
        hwr(16'd0);
        cfg_fast_rate = 1; tick();
        creq();
        cfg_gain = 2'd2;
        conv(16'h0020, 1);
        tick();

        tag = "RND";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cal_req      = (r < 6);
            conv_valid   = ($urandom_range(0, 2) == 0);
            conv_settled = ($urandom_range(0, 3) == 0);
            conv_raw     = 16'($urandom);
            host_wr      = ($urandom_range(0, 29) == 0);
            host_offset  = 16'($urandom);
            if ($urandom_range(0, 49) == 0) cfg_unipolar = ~cfg_unipolar;
            if ($urandom_range(0, 99) == 0) cfg_gain = 2'($urandom);
            if ($urandom_range(0, 99) == 0) cfg_buffered = ~cfg_buffered;
            if ($urandom_range(0, 99) == 0) cfg_fast_rate = ~cfg_fast_rate;
            rst = ($urandom_range(0, 999) == 0);
            tick();
            rst = 0;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule